// File: doc/BRIEF.md
# Converter Serial-Port State Controller

This block is the digital control side of a sampling converter that a host reads over a synchronous serial port. It steps through three states: converting, napping, and shifting out the result. A cycle counter stands in for the analog conversion, so the block itself decides when a conversion ends. At that point it captures the 16-bit value on `result_i`, pulses `conv_done_o` and powers the converter down. The word then waits for the host. The host pulls `cs_i` low, and the block shifts the word out on `sdo_o` most significant bit first, one bit for each SCK rising edge.

While the host clocks the result out, it can send a four-bit configuration on `sdi_i`. Two of these bits select the conversion speed and the sleep behaviour of the reference. These settings take effect when the next conversion begins. A new conversion starts on a CS rising edge or, once all sixteen bits are out, on an SCK falling edge. A CS rising edge before that point abandons the readout.

When sleep is selected, the reference powers down after the conversion ends. It powers up again when CS goes low. A programmable settling window then runs, and a conversion started inside that window is marked invalid. `cs_i`, `sck_i` and `sdi_i` are taken to be already synchronous to `clk_i`.

Top module: `conv_port_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (converting), `spd_o`, `slp_o`, `ref_pd_o`, `adc_pd_o`, `res_invalid_o`, `conv_done_o` and `sdo_o` are all 0.
- R2: A conversion lasts SLOW_CYC clock cycles when the speed setting applied at its start is 0, and FAST_CYC cycles when it is 1. It then moves to nap (`state_o` = 1), captures `result_i`, and raises `conv_done_o` for exactly one cycle.
- R3: `adc_pd_o` is high exactly while in nap. In nap, `cs_i` low moves the block to data output (`state_o` = 2) on the next clock.
- R4: In data output, `sdo_o` presents bit 15 of the captured word first. It advances by one bit after each SCK rising edge and reads 0 once sixteen bits have been clocked. Outside data output it is 0.
- R5: The first four SDI values, sampled on SCK rising edges in data output, are taken in this order: enable-A, enable-B, speed, sleep. They are applied at the next conversion start only if all four arrived, enable-A is 1 and enable-B is 0. Otherwise `spd_o` and `slp_o` keep their values.
- R6: After sixteen SCK rising edges, an SCK falling edge or a CS rising edge starts a conversion. An SCK falling edge earlier than that has no effect on the state.
- R7: A CS rising edge at any point in data output starts a new conversion (`state_o` = 0) on the next clock.
- R8: When the sleep setting at a conversion's start is 1, `ref_pd_o` rises as that conversion ends. It falls when the block enters data output. With sleep 0, `ref_pd_o` stays 0.
- R9: Entering data output with the reference down opens a window of WAKE_CYC cycles. A conversion started while that window is open ends with `res_invalid_o` = 1. A conversion started after the window has closed ends with `res_invalid_o` = 0.
- R10: The readout works with SCK idling either high or low, and delivers the same 16-bit word in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial configuration input |
| result_i | input | RES_W | Result from the stubbed converter core |
| sdo_o | output | 1 | Serial result output |
| conv_done_o | output | 1 | One-cycle strobe at conversion end |
| adc_pd_o | output | 1 | Converter power-down |
| ref_pd_o | output | 1 | Reference power-down |
| res_invalid_o | output | 1 | Held result taken before reference settled |
| spd_o | output | 1 | Active speed setting |
| slp_o | output | 1 | Active sleep setting |
| state_o | output | 2 | 0 converting, 1 nap, 2 data output |

## Verification
The hardest case to reach is an invalid result. The stimulus must first send sleep in one readout. It then waits out the converting and nap phases with the reference down, and starts the next readout. Finally it ends that readout quickly enough to start a conversion before the settling window closes, using a long window with a full sixteen-bit read that finishes inside it. A later readout that starts only after the window has expired, and a readout cut off after two configuration bits, show that the flag clears and that partial configurations are dropped.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;
  typedef enum logic [1:0] {
    ST_CONV = 2'd0,
    ST_NAP  = 2'd1,
    ST_DOUT = 2'd2
  } cp_state_e;

  localparam int unsigned CFG_BITS = 4;
  localparam int unsigned CFG_EN_A = 0;
  localparam int unsigned CFG_EN_B = 1;
  localparam int unsigned CFG_SPD  = 2;
  localparam int unsigned CFG_SLP  = 3;
endpackage

// File: rtl/cp_edge_det.sv
module cp_edge_det #(
  parameter int unsigned     W       = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
    assign fall_o[i] = ~sig_i[i] & prev_q[i];
  end
endmodule

// File: rtl/cp_conv_timer.sv
module cp_conv_timer #(
  parameter int unsigned SLOW_CYC = 40,
  parameter int unsigned FAST_CYC = 12,
  localparam int unsigned MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC,
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  input  logic active_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fast_q;
  logic [CNT_W-1:0] last;

  assign last   = fast_q ? CNT_W'(FAST_CYC - 1) : CNT_W'(SLOW_CYC - 1);
  assign done_o = active_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
      fast_q <= fast_i;
    end else if (active_i && !done_o) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cp_shifter.sv
module cp_shifter
  import conv_port_pkg::*;
#(
  parameter int unsigned RES_W = 16,
  localparam int unsigned BIT_W = $clog2(RES_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [RES_W-1:0]    word_i,
  input  logic                clr_i,
  input  logic                shift_i,
  input  logic                sdi_i,
  output logic                msb_o,
  output logic                full_o,
  output logic                cfg_rx_o,
  output logic [CFG_BITS-1:0] cfg_o
);
  logic [RES_W-1:0]    sh_q;
  logic [BIT_W-1:0]    bits_q;
  logic [CFG_BITS-1:0] cfg_q;

  assign msb_o    = sh_q[RES_W-1];
  assign full_o   = (bits_q == BIT_W'(RES_W));
  assign cfg_rx_o = (bits_q >= BIT_W'(CFG_BITS));
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bits_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (load_i) sh_q <= word_i;
      else if (shift_i) sh_q <= {sh_q[RES_W-2:0], 1'b0};
      if (clr_i) begin
        bits_q <= '0;
        cfg_q  <= '0;
      end else if (shift_i) begin
        bits_q <= bits_q + 1'b1;
        for (int i = 0; i < CFG_BITS; i++)
          if (bits_q == BIT_W'(i)) cfg_q[i] <= sdi_i;
      end
    end
  end
endmodule

// File: rtl/conv_port_ctrl.sv
module conv_port_ctrl
  import conv_port_pkg::*;
#(
  parameter int unsigned RES_W    = 16,
  parameter int unsigned SLOW_CYC = 40,
  parameter int unsigned FAST_CYC = 12,
  parameter int unsigned WAKE_CYC = 80,
  localparam int unsigned WAKE_W  = $clog2(WAKE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             conv_done_o,
  output logic             adc_pd_o,
  output logic             ref_pd_o,
  output logic             res_invalid_o,
  output logic             spd_o,
  output logic             slp_o,
  output logic [1:0]       state_o
);
  cp_state_e st_q, st_d;
  logic [1:0] rise, fall;
  logic cs_rise, sck_rise, sck_fall;
  logic start, shift, enter_dout, conv_end;
  logic full, cfg_rx, msb, cfg_ok, spd_new, slp_new;
  logic [CFG_BITS-1:0] cfg;
  logic spd_q, slp_q, slp_arm_q, inv_arm_q, ref_off_q, inv_q, done_q;
  logic [WAKE_W-1:0] wake_q;

  // bit 1: cs (idles high), bit 0: sck
  cp_edge_det #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk_i, .rst_ni, .sig_i({cs_i, sck_i}), .rise_o(rise), .fall_o(fall)
  );
  assign cs_rise  = rise[1];
  assign sck_rise = rise[0];
  assign sck_fall = fall[0];

  assign start      = (st_q == ST_DOUT) && (cs_rise || (sck_fall && full));
  assign shift      = (st_q == ST_DOUT) && !start && sck_rise && !full;
  assign enter_dout = (st_q == ST_NAP) && !cs_i;

  assign cfg_ok  = cfg_rx && cfg[CFG_EN_A] && !cfg[CFG_EN_B];
  assign spd_new = cfg_ok ? cfg[CFG_SPD] : spd_q;
  assign slp_new = cfg_ok ? cfg[CFG_SLP] : slp_q;

  cp_conv_timer #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .fast_i(spd_new),
    .active_i(st_q == ST_CONV), .done_o(conv_end)
  );

  cp_shifter #(.RES_W(RES_W)) u_shift (
    .clk_i, .rst_ni, .load_i(conv_end), .word_i(result_i), .clr_i(enter_dout),
    .shift_i(shift), .sdi_i, .msb_o(msb), .full_o(full), .cfg_rx_o(cfg_rx), .cfg_o(cfg)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CONV: if (conv_end)   st_d = ST_NAP;
      ST_NAP:  if (enter_dout) st_d = ST_DOUT;
      ST_DOUT: if (start)      st_d = ST_CONV;
      default:                 st_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CONV;
      spd_q     <= 1'b0;
      slp_q     <= 1'b0;
      slp_arm_q <= 1'b0;
      inv_arm_q <= 1'b0;
      ref_off_q <= 1'b0;
      inv_q     <= 1'b0;
      done_q    <= 1'b0;
      wake_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= conv_end;
      if (start) begin
        spd_q     <= spd_new;
        slp_q     <= slp_new;
        slp_arm_q <= slp_new;
        inv_arm_q <= (wake_q != '0);
      end
      if (conv_end) begin
        ref_off_q <= slp_arm_q;
        inv_q     <= inv_arm_q;
      end else if (enter_dout) begin
        ref_off_q <= 1'b0;
      end
      if (enter_dout && ref_off_q) wake_q <= WAKE_W'(WAKE_CYC);
      else if (wake_q != '0)       wake_q <= wake_q - 1'b1;
    end
  end

  assign sdo_o         = (st_q == ST_DOUT) && msb;
  assign conv_done_o   = done_q;
  assign adc_pd_o      = (st_q == ST_NAP);
  assign ref_pd_o      = ref_off_q;
  assign res_invalid_o = inv_q;
  assign spd_o         = spd_q;
  assign slp_o         = slp_q;
  assign state_o       = st_q;
endmodule

// File: rtl/conv_port_chk.sv
module conv_port_chk #(
  parameter int unsigned RES_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_i,
  input logic             conv_done_o,
  input logic             adc_pd_o,
  input logic             ref_pd_o,
  input logic             spd_o,
  input logic             slp_o,
  input logic [1:0]       state_o
);
  assert_done_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (state_o == 2'd1) && ($past(state_o) == 2'd0));

  assert_nap_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) && !cs_i |=> (state_o == 2'd2) && !adc_pd_o);

  assert_cs_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd2) && cs_i && !$past(cs_i) |=> (state_o == 2'd0));

  assert_ref_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_pd_o) |-> (state_o == 2'd1) && ($past(state_o) == 2'd0));

  assert_cfg_apply_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({spd_o, slp_o}) |-> (state_o == 2'd0) && ($past(state_o) == 2'd2));
endmodule

bind conv_port_ctrl conv_port_chk #(.RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .conv_done_o(conv_done_o),
  .adc_pd_o(adc_pd_o), .ref_pd_o(ref_pd_o), .spd_o(spd_o), .slp_o(slp_o),
  .state_o(state_o)
);

// File: tb/conv_port_ctrl_tb.sv
module conv_port_ctrl_tb;
  localparam int SLOW = 40;
  localparam int FAST = 12;
  localparam int WAKE = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [15:0] result = 16'h0000;
  logic sdo, done, adc_pd, ref_pd, inv, spd, slp;
  logic [1:0] state;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  conv_port_ctrl #(.RES_W(16), .SLOW_CYC(SLOW), .FAST_CYC(FAST), .WAKE_CYC(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi), .result_i(result),
    .sdo_o(sdo), .conv_done_o(done), .adc_pd_o(adc_pd), .ref_pd_o(ref_pd),
    .res_invalid_o(inv), .spd_o(spd), .slp_o(slp), .state_o(state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state, m_cnt, m_len, m_bits, m_wake;
  bit m_spd, m_slp, m_slp_arm, m_inv_arm, m_ref_off, m_inv, m_done, m_pcs, m_psck;
  bit m_cfg[4];
  logic [15:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_len = SLOW; m_bits = 0; m_wake = 0;
      m_spd = 0; m_slp = 0; m_slp_arm = 0; m_inv_arm = 0; m_ref_off = 0;
      m_inv = 0; m_done = 0; m_pcs = 1; m_psck = 0; m_word = '0;
      foreach (m_cfg[i]) m_cfg[i] = 0;
    end else begin
      automatic int old_wake = m_wake;
      automatic bit cs_r = cs && !m_pcs;
      automatic bit sck_r = sck && !m_psck;
      automatic bit sck_f = !sck && m_psck;
      automatic bit wake_load = 0;
      m_done = 0;
      if (m_state == 0) begin
        if (m_cnt == m_len - 1) begin
          m_state = 1; m_word = result; m_done = 1;
          m_ref_off = m_slp_arm; m_inv = m_inv_arm;
        end else m_cnt++;
      end else if (m_state == 1) begin
        if (!cs) begin
          m_state = 2; m_bits = 0;
          foreach (m_cfg[i]) m_cfg[i] = 0;
          if (m_ref_off) wake_load = 1;
          m_ref_off = 0;
        end
      end else begin
        if (cs_r || (sck_f && m_bits >= 16)) begin
          if (m_bits >= 4 && m_cfg[0] && !m_cfg[1]) begin
            m_spd = m_cfg[2]; m_slp = m_cfg[3];
          end
          m_state = 0; m_cnt = 0; m_len = m_spd ? FAST : SLOW;
          m_slp_arm = m_slp; m_inv_arm = (old_wake != 0);
        end else if (sck_r && m_bits < 16) begin
          if (m_bits < 4) m_cfg[m_bits] = sdi;
          m_bits++;
        end
      end
      if (wake_load) m_wake = WAKE;
      else if (m_wake != 0) m_wake--;
      m_pcs = cs; m_psck = sck;
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) begin
    cycles++;
    if (cmp_en) begin
      automatic bit e_sdo = (m_state == 2 && m_bits < 16) ? m_word[15 - m_bits] : 1'b0;
      chk(state == m_state[1:0], "R6 R7 state", state, m_state);
      chk(done == m_done, "R2 conv_done", done, m_done);
      chk(adc_pd == (m_state == 1), "R3 adc_pd", adc_pd, m_state == 1);
      chk(sdo == e_sdo, "R4 sdo", sdo, e_sdo);
      chk(spd == m_spd && slp == m_slp, "R5 spd/slp", {spd, slp}, {m_spd, m_slp});
      chk(ref_pd == m_ref_off, "R8 ref_pd", ref_pd, m_ref_off);
      chk(inv == m_inv, "R9 invalid", inv, m_inv);
    end
    if (cycles > 40000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 40000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_nap();
    while (state != 2'd1) @(negedge clk);
    @(negedge clk);
  endtask

  // cfg order: {en_a, en_b, spd, slp}; end_cs: finish with CS rise
  task automatic readout(input int nbits, input logic [3:0] cfg, input bit idle_hi,
                         input bit end_cs, output logic [15:0] got);
    got = '0;
    sck = idle_hi;
    cs = 1'b0;
    repeat (2) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      sdi = (b < 4) ? cfg[3 - b] : 1'b0;
      if (idle_hi) begin
        sck = 1'b0; repeat (2) @(negedge clk);
        got[15 - b] = sdo;
        sck = 1'b1; repeat (2) @(negedge clk);
      end else begin
        got[15 - b] = sdo;
        sck = 1'b1; repeat (2) @(negedge clk);
        sck = 1'b0; repeat (2) @(negedge clk);
      end
    end
    if (end_cs || nbits < 16) begin
      cs = 1'b1;
    end else if (idle_hi) begin
      sck = 1'b0; repeat (2) @(negedge clk);
      sck = 1'b1;
    end
    repeat (2) @(negedge clk);
    cs = 1'b1;
  endtask

  logic [15:0] got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(state == 2'd0 && !spd && !slp && !ref_pd && !adc_pd && !inv && !done && !sdo,
        "R1 reset", {state, spd, slp, ref_pd, adc_pd, inv, done, sdo}, 0);
    cmp_en = 1'b1;

    // idle-high read, valid config sets speed
    result = 16'hA5C3;
    wait_nap();
    readout(16, 4'b1010, 1'b1, 1'b1, got);
    chk(got == 16'hA5C3, "R10 idle-high word", got, 16'hA5C3);

    // idle-low read, disabled config ignored, SCK fall ends it
    result = 16'h3C5A;
    wait_nap();
    readout(16, 4'b1101, 1'b0, 1'b0, got);
    chk(got == 16'h3C5A, "R10 idle-low word", got, 16'h3C5A);
    chk(spd && !slp, "R5 config ignored", {spd, slp}, 2'b10);

    // abort after 7 bits, config slow + sleep
    result = 16'h0F0F;
    wait_nap();
    readout(7, 4'b1001, 1'b1, 1'b1, got);
    chk(!spd && slp, "R5 R7 applied on abort", {spd, slp}, 2'b01);

    // reference down after the conversion
    result = 16'hFFFF;
    wait_nap();
    chk(ref_pd == 1'b1, "R8 reference off in nap", ref_pd, 1);
    readout(16, 4'b1000, 1'b1, 1'b0, got);
    chk(got == 16'hFFFF, "R10 word after wake", got, 16'hFFFF);

    // started inside settling window
    result = 16'h1234;
    wait_nap();
    chk(inv == 1'b1, "R9 invalid inside window", inv, 1);
    chk(ref_pd == 1'b0, "R8 reference stays on", ref_pd, 0);
    repeat (WAKE + 5) @(negedge clk);
    readout(2, 4'b1011, 1'b0, 1'b1, got);
    chk(!spd && !slp, "R5 partial config dropped", {spd, slp}, 2'b00);

    result = 16'h8001;
    wait_nap();
    chk(inv == 1'b0, "R9 valid after window", inv, 0);
    readout(16, 4'b0000, 1'b0, 1'b1, got);
    chk(got == 16'h8001, "R4 boundary word", got, 16'h8001);
    wait_nap();
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule